// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit stands between several requesting masters and one single-port memory. Each master presents one request at a time with an opcode, a word address, a data operand and a compare operand. A round-robin arbiter picks one master. The unit then reads the addressed word and, in the very next cycle, writes back a value computed from the old word and the operands. No other access reaches the memory between that read and that write.

Every operation returns the old word, a one-bit flag and the identifier of the master that issued it, a fixed three cycles after the request was accepted. The same sequence carries plain loads and stores. A lock word can therefore be taken with test-and-set and released with an ordinary store of zero, and counters can be bumped with fetch-and-add or guarded with compare-and-swap.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, with no request pending, `rsp_valid`, `mem_en` and every bit of `req_ready` are 0.
- R2: Exchange (opcode 2) stores the data operand at the address and returns the previous word with flag 0.
- R3: Test-and-set (opcode 3) always stores the value 1 and returns the previous word with a flag that is 1 exactly when that previous word was nonzero.
- R4: Fetch-and-add (opcode 4) returns the previous word with flag 0 and stores the previous word plus the data operand, wrapping modulo 2^DW.
- R5: Compare-and-swap (opcode 5) whose compare operand equals the stored word stores the data operand and returns the previous word with flag 1.
- R6: Compare-and-swap whose compare operand differs from the stored word writes nothing to memory and returns the stored word with flag 0.
- R7: Load (opcode 0) returns the stored word without writing. Store (opcode 1) writes the data operand and returns the previous word. A store of 0 releases a lock word taken by test-and-set.
- R8: Every memory write is issued in the cycle right after a read of the same address. The unit grants no new request while an operation is in progress.
- R9: At most one master is granted per cycle. Under contention, grants rotate round-robin, starting from the index after the last master served.
- R10: The response appears exactly three cycles after the cycle in which `req_valid` and `req_ready` were both high, and `rsp_id` equals the index of the accepted master.
- R11: The reserved opcodes 6 and 7 behave as loads: they return the stored word with flag 0 and leave memory unchanged.
- R12: When several masters run test-and-set spin locks around a non-atomic read-increment-store, no two are ever inside the guarded section at once, and both the guarded counter and a fetch-and-add counter end at the total number of increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_MST | Request valid, one bit per master |
| req_ready | output | N_MST | Request accepted this cycle, one bit per master |
| req_op | input | N_MST*3 | Opcode per master (0 load, 1 store, 2 exchange, 3 test-and-set, 4 fetch-and-add, 5 compare-and-swap) |
| req_addr | input | N_MST*AW | Word address per master |
| req_wdata | input | N_MST*DW | Data operand per master |
| req_cmp | input | N_MST*DW | Compare operand per master (compare-and-swap only) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_id | output | ID_W | Index of the master the response belongs to |
| rsp_data | output | DW | Word held at the address before the operation |
| rsp_flag | output | 1 | Test-and-set: lock already taken; compare-and-swap: swap done |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read |

## Verification
A single master walks one address through a chain of operations. Each step depends on the word left by the one before, so a wrong written value shows up in the next returned value. Compare-and-swap is tried once with a matching and once with a stale compare value, and test-and-set once on a free word and once on a taken one, to separate the success and failure paths. Four masters raising requests in the same cycle expose the grant order. Four masters spinning on one lock around a non-atomic increment expose any broken indivisibility or exclusion, since the counters would come up short.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FADD  = 3'd4,
    OP_CAS   = 3'd5
  } rmw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } rmw_state_e;

endpackage

// File: rtl/rmw_rr_arbiter.sv
module rmw_rr_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          hit;
  int            idx;

  // search from the rotating pointer for the first requester
  always_comb begin
    gnt     = '0;
    gnt_idx = ptr_q;
    hit     = 1'b0;
    idx     = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!hit && en && req[idx]) begin
        hit        = 1'b1;
        gnt[idx]   = 1'b1;
        gnt_idx    = IW'(idx);
      end
    end
  end

  // pointer moves one past the winner on every grant
  always_comb begin
    ptr_d = ptr_q;
    if (hit) begin
      if (int'(gnt_idx) == N - 1) ptr_d = '0;
      else                        ptr_d = gnt_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (hit) ptr_q <= ptr_d;
  end

  assert_gnt_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_gnt_in_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> (|(gnt & req)));

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  old_word,
  input  logic [DW-1:0]  opnd,
  input  logic [DW-1:0]  cmp,
  output logic           wr_en,
  output logic [DW-1:0]  wr_data,
  output logic           flag
);

  logic match;

  always_comb begin
    match   = (old_word == cmp);
    wr_en   = 1'b0;
    wr_data = opnd;
    flag    = 1'b0;
    case (op)
      OP_STORE, OP_SWAP: wr_en = 1'b1;
      OP_TAS: begin
        wr_en   = 1'b1;
        wr_data = DW'(1);
        flag    = |old_word;
      end
      OP_FADD: begin
        wr_en   = 1'b1;
        wr_data = old_word + opnd;
      end
      OP_CAS: begin
        wr_en = match;
        flag  = match;
      end
      default: ;  // load and reserved codes: read only
    endcase
  end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int ID_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MST-1:0]     req_valid,
  output logic [N_MST-1:0]     req_ready,
  input  logic [N_MST*OPW-1:0] req_op,
  input  logic [N_MST*AW-1:0]  req_addr,
  input  logic [N_MST*DW-1:0]  req_wdata,
  input  logic [N_MST*DW-1:0]  req_cmp,
  output logic                 rsp_valid,
  output logic [ID_W-1:0]      rsp_id,
  output logic [DW-1:0]        rsp_data,
  output logic                 rsp_flag,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata
);

  rmw_state_e     st_q, st_d;
  logic           idle;
  logic           accept;
  logic [N_MST-1:0] gnt;
  logic [ID_W-1:0]  gnt_idx;

  logic [OPW-1:0] op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  opnd_q;
  logic [DW-1:0]  cmp_q;
  logic [ID_W-1:0] id_q;

  logic           rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]  rsp_data_q;
  logic           rsp_flag_q;

  logic           alu_we;
  logic [DW-1:0]  alu_wdata;
  logic           alu_flag;
  logic           wr_phase;

  assign idle = (st_q == ST_IDLE);

  rmw_rr_arbiter #(.N(N_MST)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (idle),
    .req     (req_valid),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  assign req_ready = gnt;
  assign accept    = |gnt;

  rmw_alu #(.DW(DW)) u_alu (
    .op       (op_q),
    .old_word (mem_rdata),
    .opnd     (opnd_q),
    .cmp      (cmp_q),
    .wr_en    (alu_we),
    .wr_data  (alu_wdata),
    .flag     (alu_flag)
  );

  // sequencer: idle -> read -> write/complete -> idle
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign wr_phase    = (st_q == ST_WR);
  assign rsp_valid_d = wr_phase;

  always_comb begin
    mem_en    = (st_q == ST_RD) || (wr_phase && alu_we);
    mem_we    = wr_phase && alu_we;
    mem_addr  = addr_q;
    mem_wdata = alu_wdata;
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  // captured request, enabled by the handshake
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= req_op[gnt_idx*OPW +: OPW];
      addr_q <= req_addr[gnt_idx*AW +: AW];
      opnd_q <= req_wdata[gnt_idx*DW +: DW];
      cmp_q  <= req_cmp[gnt_idx*DW +: DW];
      id_q   <= gnt_idx;
    end
  end

  // result capture, enabled in the write phase
  always_ff @(posedge clk) begin
    if (wr_phase) begin
      rsp_data_q <= mem_rdata;
      rsp_flag_q <= alu_flag;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_id    = id_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_flag  = rsp_flag_q;

  assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && ($past(mem_addr) == mem_addr)));

  assert_busy_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (req_ready == '0));

  assert_rsp_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |-> ##3 rsp_valid);

  assert_tas_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_TAS) |-> (rsp_flag == (rsp_data != '0)));

  assert_fadd_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && op_q == OP_FADD) |=> (rsp_data + opnd_q == $past(mem_wdata)));

  assert_swap_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_SWAP) |-> ($past(mem_en && mem_we) && $past(mem_wdata) == opnd_q));

  assert_cas_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_CAS && rsp_flag) |-> $past(mem_en && mem_we));

  assert_cas_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_CAS && !rsp_flag) |-> $past(!(mem_en && mem_we)));

endmodule

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;

  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam int ITERS = 5;
  localparam logic [AW-1:0] A_T   = 8'h10;
  localparam logic [AW-1:0] A_LCK = 8'h20;
  localparam logic [AW-1:0] A_C1  = 8'h21;
  localparam logic [AW-1:0] A_C2  = 8'h22;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] wd;
    logic [31:0] cm;
    logic [31:0] exp_d;
    logic        exp_f;
    logic [7:0]  rq;
  } vec_t;

  // chain on one address, starting from 0
  localparam vec_t VEC [17] = '{
    '{3'd1, 32'h55,       32'h0,  32'h0,  1'b0, 8'd7 },  // R7 store
    '{3'd0, 32'h0,        32'h0,  32'h55, 1'b0, 8'd7 },  // R7 load
    '{3'd2, 32'hAA,       32'h0,  32'h55, 1'b0, 8'd2 },  // R2 exchange
    '{3'd0, 32'h0,        32'h0,  32'hAA, 1'b0, 8'd2 },  // R2 readback
    '{3'd4, 32'h3,        32'h0,  32'hAA, 1'b0, 8'd4 },  // R4 add
    '{3'd0, 32'h0,        32'h0,  32'hAD, 1'b0, 8'd4 },  // R4 readback
    '{3'd5, 32'h7,        32'hAD, 32'hAD, 1'b1, 8'd5 },  // R5 cas hit
    '{3'd5, 32'h9,        32'hAD, 32'h7,  1'b0, 8'd6 },  // R6 cas miss
    '{3'd0, 32'h0,        32'h0,  32'h7,  1'b0, 8'd6 },  // R6 unchanged
    '{3'd1, 32'h0,        32'h0,  32'h7,  1'b0, 8'd7 },  // R7 release
    '{3'd3, 32'h0,        32'h0,  32'h0,  1'b0, 8'd3 },  // R3 free
    '{3'd3, 32'h0,        32'h0,  32'h1,  1'b1, 8'd3 },  // R3 taken
    '{3'd0, 32'h0,        32'h0,  32'h1,  1'b0, 8'd3 },  // R3 wrote 1
    '{3'd6, 32'h33,       32'h0,  32'h1,  1'b0, 8'd11},  // R11 reserved
    '{3'd0, 32'h0,        32'h0,  32'h1,  1'b0, 8'd11},  // R11 unchanged
    '{3'd4, 32'hFFFFFFFF, 32'h0,  32'h1,  1'b0, 8'd4 },  // R4 wrap
    '{3'd0, 32'h0,        32'h0,  32'h0,  1'b0, 8'd4 }   // R4 wrap result
  };

  logic              clk;
  logic              rst_n;
  logic [N-1:0]      req_valid;
  logic [N-1:0]      req_ready;
  logic [N*3-1:0]    req_op;
  logic [N*AW-1:0]   req_addr;
  logic [N*DW-1:0]   req_wdata;
  logic [N*DW-1:0]   req_cmp;
  logic              rsp_valid;
  logic [IW-1:0]     rsp_id;
  logic [DW-1:0]     rsp_data;
  logic              rsp_flag;
  logic              mem_en;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic [DW-1:0]     mem_rdata;

  int total = 0;
  int bad   = 0;
  int in_cs = 0;
  int max_cs = 0;
  int viol  = 0;
  int order [8];
  int n_ord = 0;
  logic log_en = 1'b0;
  logic prev_rd;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] mem [256];

  atomic_rmw_unit #(.N_MST(N), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_flag(rsp_flag),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // single-port memory, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  // R8: a write must follow a read of the same address directly
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we && !(prev_rd && prev_addr == mem_addr)) viol++;
      prev_rd   <= mem_en && !mem_we;
      prev_addr <= mem_addr;
    end else begin
      prev_rd   <= 1'b0;
      prev_addr <= '0;
    end
  end

  // grant order logging for R9
  always @(posedge clk) begin
    if (log_en) begin
      for (int i = 0; i < N; i++)
        if (req_valid[i] && req_ready[i] && n_ord < 8) begin
          order[n_ord] = i;
          n_ord++;
        end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int m, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [DW-1:0] cm,
                       output logic [DW-1:0] d, output logic f);
    int lat;
    @(negedge clk);
    req_op[m*3 +: 3]     = op;
    req_addr[m*AW +: AW] = a;
    req_wdata[m*DW +: DW] = wd;
    req_cmp[m*DW +: DW]  = cm;
    req_valid[m]         = 1'b1;
    #1;
    while (!req_ready[m]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid[m] = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 3, "R10 latency", lat, 3);
    chk(int'(rsp_id) == m, "R10 id", rsp_id, m);
    d = rsp_data;
    f = rsp_flag;
  endtask

  task automatic master_proc(input int m);
    logic [DW-1:0] d;
    logic f;
    for (int it = 0; it < ITERS; it++) begin
      f = 1'b1;
      while (f) do_op(m, 3'd3, A_LCK, '0, '0, d, f);
      in_cs++;
      if (in_cs > max_cs) max_cs = in_cs;
      do_op(m, 3'd0, A_C1, '0, '0, d, f);
      do_op(m, 3'd1, A_C1, d + 1, '0, d, f);
      do_op(m, 3'd4, A_C2, 32'd1, '0, d, f);
      in_cs--;
      do_op(m, 3'd1, A_LCK, '0, '0, d, f);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic f;
    req_valid = '0;
    req_op    = '0;
    req_addr  = '0;
    req_wdata = '0;
    req_cmp   = '0;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_en == 1'b0, "R1 mem_en", mem_en, 0);
    chk(req_ready == '0, "R1 req_ready", req_ready, 0);

    // vector table on master 0
    for (int v = 0; v < 17; v++) begin
      do_op(0, VEC[v].op, A_T, VEC[v].wd, VEC[v].cm, d, f);
      if (d !== VEC[v].exp_d)
        chk(1'b0, $sformatf("R%0d vec%0d data", VEC[v].rq, v), d, VEC[v].exp_d);
      else
        chk(1'b1, "", 0, 0);
      chk(f === VEC[v].exp_f, $sformatf("R%0d vec%0d flag", VEC[v].rq, v), f, VEC[v].exp_f);
    end

    // R9 simultaneous requests from all masters rotate
    log_en = 1'b1;
    fork
      begin logic [DW-1:0] x; logic y; do_op(0, 3'd0, A_T, '0, '0, x, y); end
      begin logic [DW-1:0] x; logic y; do_op(1, 3'd0, A_T, '0, '0, x, y); end
      begin logic [DW-1:0] x; logic y; do_op(2, 3'd0, A_T, '0, '0, x, y); end
      begin logic [DW-1:0] x; logic y; do_op(3, 3'd0, A_T, '0, '0, x, y); end
    join
    log_en = 1'b0;
    chk(n_ord == 4, "R9 grant count", n_ord, 4);
    for (int i = 0; i < 3; i++)
      chk(order[i+1] == (order[i] + 1) % N, "R9 rotation", order[i+1], (order[i] + 1) % N);

    // R12 contention: spin locks plus atomic counter
    fork
      master_proc(0);
      master_proc(1);
      master_proc(2);
      master_proc(3);
    join
    chk(max_cs == 1, "R12 exclusion", max_cs, 1);
    do_op(0, 3'd0, A_C1, '0, '0, d, f);
    chk(d == N * ITERS, "R12 guarded counter", d, N * ITERS);
    do_op(0, 3'd0, A_C2, '0, '0, d, f);
    chk(d == N * ITERS, "R12 fetch-add counter", d, N * ITERS);
    do_op(0, 3'd0, A_LCK, '0, '0, d, f);
    chk(d == 0, "R7 lock released", d, 0);
    chk(viol == 0, "R8 read-write adjacency", viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule